// File: doc/BRIEF.md
# Page Walk Memory Request Issuer

This block stands between a hardware page table walker and a memory port that is allowed to refuse an offered request. The walker hands it at most one table read at a time, together with any entry write-backs (accessed-bit updates) that the walk produces. The block keeps the read in a single slot and the write-backs in a small stack. It offers them one per cycle on a valid/accept port and keeps a count of the requests that are outstanding in memory.

Any refusal by the port stops all issue until the port sends a retry pulse. A response that memory marks as refused (a negative acknowledge) carries the original request back and is offered again on the next cycle. A read response that completes normally is handed to the walker one cycle later. Issue pauses for that cycle so that the walker can queue the follow-on read and any write-back first. A done output tells the walker that all of the walk's memory traffic has drained.

Top module: `walk_req_issuer`

## Requirements
- R1: Whenever the issuer may offer and a read is pending, the read is offered (req_is_write = 0) ahead of every queued write-back.
- R2: An offer with req_accept low sets a retrying state. From the next cycle, no read or write-back is offered until a retry_pulse has been seen at a clock edge. From the following cycle, offering restarts with the pending read.
- R3: Write-backs are offered newest first (last in, first out), one per cycle, for as long as the port keeps accepting.
- R4: The outstanding count rises by one for each accepted offer and falls by one for each response, refused or not. walk_done stays low while any request is outstanding.
- R5: A response with rsp_nack high is offered again on the next cycle with its own address, data and type. This happens even while retrying.
- R6: If that re-offer is refused, a read goes back to the read slot and a write goes back onto the stack, and retrying is set. After a retry pulse, the request is offered again with its original type and address.
- R7: A read response that is not refused gives rdata_valid high with rdata equal to rsp_data one cycle later. Nothing is offered in that cycle. A read and a write-back queued in that cycle are then offered read first.
- R8: walk_done is high exactly when nothing is outstanding, no read is pending, the stack is empty, no re-offer is waiting, and no read data is being handed over.
- R9: The write-back stack holds WQ_DEPTH (default 4) entries. A push to a full stack is dropped and sets err_wq_ovf, which stays high until reset.
- R10: A read enqueued while a read is still pending is dropped: the pending read is kept and err_rd_dup is set and stays high until reset.
- R11: After reset, req_valid and rdata_valid are low, walk_done is high and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_enq_valid | input | 1 | Queue a table read |
| rd_enq_addr | input | 48 | Address of the queued read |
| wr_enq_valid | input | 1 | Push an entry write-back |
| wr_enq_addr | input | 48 | Write-back address |
| wr_enq_data | input | 64 | Write-back entry value |
| req_valid | output | 1 | A request is offered to the port |
| req_is_write | output | 1 | Offered request is a write-back |
| req_addr | output | 48 | Offered address |
| req_data | output | 64 | Offered write data (zero for reads) |
| req_accept | input | 1 | Port takes the offer this cycle; low with req_valid is a refusal |
| retry_pulse | input | 1 | Port can take offers again |
| rsp_valid | input | 1 | Response from memory |
| rsp_nack | input | 1 | Response is a refusal carrying the original request |
| rsp_is_write | input | 1 | Response belongs to a write |
| rsp_addr | input | 48 | Address of the original request |
| rsp_data | input | 64 | Read data, or original write data on a refusal |
| rdata_valid | output | 1 | Read data handed to the walker |
| rdata | output | 64 | Read data |
| walk_done | output | 1 | All of the walk's memory traffic has drained |
| err_wq_ovf | output | 1 | Sticky: push to a full write-back stack |
| err_rd_dup | output | 1 | Sticky: second read queued while one was pending |

## Verification
A retrying flag stuck high shows as req_valid staying low after a retry pulse. A flag that never sets shows as offers in the cycle after a refusal. Both are visible within one cycle of the edge that should have changed it. A wrong stack pointer shows on req_addr as the wrong write-back order, or as a missing or repeated entry, as soon as the stack drains. A miscount of outstanding requests shows as walk_done rising while a response is still due, or never rising once the last response has arrived.

// File: rtl/walk_iss_pkg.sv
// Shared widths and types for the walk request issuer.
package walk_iss_pkg;
    localparam int ADDR_W = 48;
    localparam int DATA_W = 64;

    // One write-back held on the stack or awaiting re-offer.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wb_ent_t;

    // Which holder drives the request port this cycle.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_RESEND = 2'd1,
        SRC_READ   = 2'd2,
        SRC_WRITE  = 2'd3
    } offer_src_e;
endpackage

// File: rtl/walk_wb_stack.sv
// Last-in first-out store for write-backs.
// Up to two pushes and one pop in a cycle: the pop happens first, then push_a, then push_b.
// A push that finds the stack full is dropped and flags ovf for that cycle.
// Assumes pop is asserted only while the stack is non-empty.
module walk_wb_stack
    import walk_iss_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pop,
    input  logic    push_a,
    input  wb_ent_t ent_a,
    input  logic    push_b,
    input  wb_ent_t ent_b,
    output wb_ent_t top,
    output logic    empty,
    output logic    ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    wb_ent_t          mem   [DEPTH];
    wb_ent_t          mem_n [DEPTH];
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] top_idx;

    // Next contents: pop, then each push in turn
    always_comb begin
        mem_n = mem;
        cnt_n = cnt;
        ovf   = 1'b0;
        if (pop && cnt_n != '0) begin
            cnt_n = cnt_n - 1'b1;
        end
        if (push_a) begin
            if (cnt_n < FULL_CNT) begin
                mem_n[cnt_n[IDX_W-1:0]] = ent_a;
                cnt_n = cnt_n + 1'b1;
            end else begin
                ovf = 1'b1;
            end
        end
        if (push_b) begin
            if (cnt_n < FULL_CNT) begin
                mem_n[cnt_n[IDX_W-1:0]] = ent_b;
                cnt_n = cnt_n + 1'b1;
            end else begin
                ovf = 1'b1;
            end
        end
    end

    // State update; only the count needs a reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_n;
        end
        mem <= mem_n;
    end

    // Newest entry is presented on top
    always_comb begin
        top_idx = cnt - 1'b1;
        top     = mem[top_idx[IDX_W-1:0]];
        empty   = (cnt == '0);
    end
endmodule

// File: rtl/walk_flight_ctr.sv
// Counts requests accepted by memory that still await a response.
// Assumes dec is never asserted alone while the count is zero.
module walk_flight_ctr #(
    parameter int MAX_INFL = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic zero
);
    localparam int CNT_W = $clog2(MAX_INFL + 1);

    logic [CNT_W-1:0] cnt;

    // Up on accept, down on response, unchanged when both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= (cnt != '0) ? cnt - 1'b1 : cnt;
                default: cnt <= cnt;
            endcase
        end
    end

    // Drained indication
    assign zero = (cnt == '0);
endmodule

// File: rtl/walk_req_issuer.sv
// Issues a page walk's table reads and entry write-backs to a memory port
// that may refuse an offer.
// Offer priority in each cycle: a refused-response re-offer first, then the
// pending read, then the newest write-back. The last two are held back while
// retrying and in the read-data hand-over cycle.
// Assumes one response per cycle at most. A refused response carries its
// original address, data and type.
module walk_req_issuer
    import walk_iss_pkg::*;
#(
    parameter int WQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_enq_valid,
    input  logic [ADDR_W-1:0] rd_enq_addr,
    input  logic              wr_enq_valid,
    input  logic [ADDR_W-1:0] wr_enq_addr,
    input  logic [DATA_W-1:0] wr_enq_data,
    output logic              req_valid,
    output logic              req_is_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_data,
    input  logic              req_accept,
    input  logic              retry_pulse,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic              rsp_is_write,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rdata_valid,
    output logic [DATA_W-1:0] rdata,
    output logic              walk_done,
    output logic              err_wq_ovf,
    output logic              err_rd_dup
);
    localparam int MAX_INFL = WQ_DEPTH + 2;

    // Read slot
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr;
    // Re-offer holder for a refused response
    logic              resend_vld;
    logic              resend_is_write;
    wb_ent_t           resend_ent;
    // Issue control
    logic              retrying;
    offer_src_e        src;
    logic              taken, refused;
    logic              wq_pop, ret_wr, ret_rd;
    logic              slot_busy;
    logic              stk_empty, stk_ovf;
    wb_ent_t           stk_top, enq_ent;
    logic              infl_zero;

    assign enq_ent = '{addr: wr_enq_addr, data: wr_enq_data};

    // Choose the holder that drives the port this cycle
    always_comb begin
        if (resend_vld) begin
            src = SRC_RESEND;
        end else if (!retrying && !rdata_valid && rd_pend) begin
            src = SRC_READ;
        end else if (!retrying && !rdata_valid && !stk_empty) begin
            src = SRC_WRITE;
        end else begin
            src = SRC_NONE;
        end
    end

    // Drive the request port from the chosen holder
    always_comb begin
        req_valid    = (src != SRC_NONE);
        req_is_write = 1'b0;
        req_addr     = '0;
        req_data     = '0;
        unique case (src)
            SRC_RESEND: begin
                req_is_write = resend_is_write;
                req_addr     = resend_ent.addr;
                req_data     = resend_is_write ? resend_ent.data : '0;
            end
            SRC_READ: begin
                req_addr     = rd_addr;
            end
            SRC_WRITE: begin
                req_is_write = 1'b1;
                req_addr     = stk_top.addr;
                req_data     = stk_top.data;
            end
            default: ;
        endcase
    end

    // Handshake outcome and where a refused re-offer returns to
    always_comb begin
        taken     = req_valid && req_accept;
        refused   = req_valid && !req_accept;
        wq_pop    = (src == SRC_WRITE) && taken;
        ret_wr    = (src == SRC_RESEND) && refused && resend_is_write;
        ret_rd    = (src == SRC_RESEND) && refused && !resend_is_write;
        slot_busy = (rd_pend && !((src == SRC_READ) && taken)) || ret_rd;
    end

    // Retrying flag: set by any refusal, cleared by a retry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retrying <= 1'b0;
        end else if (refused) begin
            retrying <= 1'b1;
        end else if (retry_pulse) begin
            retrying <= 1'b0;
        end
    end

    // Read slot: cleared on accept, refilled by a returned read or a new enqueue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend    <= 1'b0;
            rd_addr    <= '0;
            err_rd_dup <= 1'b0;
        end else begin
            if ((src == SRC_READ) && taken) begin
                rd_pend <= 1'b0;
            end
            if (ret_rd) begin
                rd_pend <= 1'b1;
                rd_addr <= resend_ent.addr;
            end
            if (rd_enq_valid) begin
                if (slot_busy) begin
                    err_rd_dup <= 1'b1;
                end else begin
                    rd_pend <= 1'b1;
                    rd_addr <= rd_enq_addr;
                end
            end
        end
    end

    // Re-offer holder: loaded by a refused response, emptied once offered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resend_vld      <= 1'b0;
            resend_is_write <= 1'b0;
            resend_ent      <= '0;
        end else if (rsp_valid && rsp_nack) begin
            resend_vld      <= 1'b1;
            resend_is_write <= rsp_is_write;
            resend_ent      <= '{addr: rsp_addr, data: rsp_data};
        end else if (src == SRC_RESEND) begin
            resend_vld      <= 1'b0;
        end
    end

    // Read data hand-over to the walker, one cycle after the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_valid <= 1'b0;
            rdata       <= '0;
        end else begin
            rdata_valid <= rsp_valid && !rsp_nack && !rsp_is_write;
            if (rsp_valid && !rsp_nack && !rsp_is_write) begin
                rdata <= rsp_data;
            end
        end
    end

    // Sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_wq_ovf <= 1'b0;
        end else if (stk_ovf) begin
            err_wq_ovf <= 1'b1;
        end
    end

    walk_wb_stack #(
        .DEPTH (WQ_DEPTH)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop    (wq_pop),
        .push_a (ret_wr),
        .ent_a  (resend_ent),
        .push_b (wr_enq_valid),
        .ent_b  (enq_ent),
        .top    (stk_top),
        .empty  (stk_empty),
        .ovf    (stk_ovf)
    );

    walk_flight_ctr #(
        .MAX_INFL (MAX_INFL)
    ) u_flight (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (taken),
        .dec   (rsp_valid),
        .zero  (infl_zero)
    );

    // Drained when nothing is held, outstanding or being handed over
    assign walk_done = infl_zero && !rd_pend && stk_empty && !resend_vld && !rdata_valid;
endmodule

// File: rtl/walk_req_issuer_chk.sv
// Temporal checks for walk_req_issuer, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module walk_req_issuer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_is_write,
    input logic req_accept,
    input logic retrying,
    input logic resend_vld,
    input logic rd_pend,
    input logic rsp_valid,
    input logic rsp_nack,
    input logic rsp_is_write,
    input logic rdata_valid,
    input logic walk_done,
    input logic err_wq_ovf,
    input logic err_rd_dup
);
    // A write-back never goes out ahead of a pending read
    assert_read_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_write && !resend_vld) |-> !rd_pend);

    // A refusal leads to the retrying state
    assert_refusal_sets_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_accept) |=> retrying);

    // Only a re-offer may appear while retrying
    assert_quiet_retrying_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (retrying && !resend_vld) |-> !req_valid);

    // A refused response is offered on the next cycle
    assert_nack_reoffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_nack) |=> req_valid);

    // A completed read is handed over on the next cycle
    assert_read_handover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_nack && !rsp_is_write) |=> rdata_valid);

    // No offer during the hand-over cycle
    assert_handover_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> !req_valid);

    // Drained means nothing is being offered
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> !req_valid);

    // Error flags hold until reset
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_wq_ovf |=> err_wq_ovf);

    assert_dup_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_rd_dup |=> err_rd_dup);
endmodule

bind walk_req_issuer walk_req_issuer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_write (req_is_write),
    .req_accept   (req_accept),
    .retrying     (retrying),
    .resend_vld   (resend_vld),
    .rd_pend      (rd_pend),
    .rsp_valid    (rsp_valid),
    .rsp_nack     (rsp_nack),
    .rsp_is_write (rsp_is_write),
    .rdata_valid  (rdata_valid),
    .walk_done    (walk_done),
    .err_wq_ovf   (err_wq_ovf),
    .err_rd_dup   (err_rd_dup)
);

// File: tb/sim_walk_req_issuer.sv
// Self-checking bench for walk_req_issuer. Inputs change 2 ns after each
// rising edge; outputs are sampled in the same window.
module sim_walk_req_issuer;
    import walk_iss_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_enq_valid = 1'b0;
    logic [ADDR_W-1:0] rd_enq_addr = '0;
    logic              wr_enq_valid = 1'b0;
    logic [ADDR_W-1:0] wr_enq_addr = '0;
    logic [DATA_W-1:0] wr_enq_data = '0;
    logic              req_valid, req_is_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_data;
    logic              req_accept = 1'b0;
    logic              retry_pulse = 1'b0;
    logic              rsp_valid = 1'b0, rsp_nack = 1'b0, rsp_is_write = 1'b0;
    logic [ADDR_W-1:0] rsp_addr = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              rdata_valid;
    logic [DATA_W-1:0] rdata;
    logic              walk_done, err_wq_ovf, err_rd_dup;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Write-back vectors: pushed in index order, expected out in reverse
    localparam logic [ADDR_W-1:0] WB_VEC [4] = '{48'h0000_1000, 48'h0000_2008, 48'h0000_3010, 48'h0000_4018};
    localparam logic [DATA_W-1:0] WB_XOR = 64'hA5A5_0000_0000_0021;

    walk_req_issuer u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_enq_valid(rd_enq_valid), .rd_enq_addr(rd_enq_addr),
        .wr_enq_valid(wr_enq_valid), .wr_enq_addr(wr_enq_addr), .wr_enq_data(wr_enq_data),
        .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr), .req_data(req_data),
        .req_accept(req_accept), .retry_pulse(retry_pulse),
        .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_is_write(rsp_is_write),
        .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .rdata_valid(rdata_valid), .rdata(rdata),
        .walk_done(walk_done), .err_wq_ovf(err_wq_ovf), .err_rd_dup(err_rd_dup)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one cycle and drop all one-cycle inputs
    task automatic step();
        @(posedge clk);
        #2;
        rd_enq_valid = 1'b0;
        wr_enq_valid = 1'b0;
        retry_pulse  = 1'b0;
        rsp_valid    = 1'b0;
        rsp_nack     = 1'b0;
        rsp_is_write = 1'b0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        req_accept = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic push_wb(input logic [ADDR_W-1:0] a);
        wr_enq_valid = 1'b1;
        wr_enq_addr  = a;
        wr_enq_data  = {16'h0, a} ^ WB_XOR;
    endtask

    task automatic respond(input logic nack, input logic is_wr,
                           input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        rsp_valid    = 1'b1;
        rsp_nack     = nack;
        rsp_is_write = is_wr;
        rsp_addr     = a;
        rsp_data     = d;
    endtask

    task automatic expect_offer(input string tag, input logic is_wr, input logic [ADDR_W-1:0] a);
        chk({tag, " valid"}, 64'(req_valid), 64'd1);
        chk({tag, " type"}, 64'(req_is_write), 64'(is_wr));
        chk({tag, " addr"}, 64'(req_addr), 64'(a));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // ---- R11 reset state
        apply_reset();
        chk("R11 req_valid", 64'(req_valid), 64'd0);
        chk("R11 rdata_valid", 64'(rdata_valid), 64'd0);
        chk("R11 walk_done", 64'(walk_done), 64'd1);
        chk("R11 err_wq_ovf", 64'(err_wq_ovf), 64'd0);
        chk("R11 err_rd_dup", 64'(err_rd_dup), 64'd0);

        // ---- R1 R2 R3: read and four write-backs held behind a refusal
        req_accept   = 1'b0;
        rd_enq_valid = 1'b1;
        rd_enq_addr  = 48'h00AB_C000;
        push_wb(WB_VEC[0]);
        step();
        expect_offer("R1 read first", 1'b0, 48'h00AB_C000);
        push_wb(WB_VEC[1]);
        step();
        chk("R2 quiet after refusal", 64'(req_valid), 64'd0);
        push_wb(WB_VEC[2]);
        step();
        chk("R2 quiet while retrying", 64'(req_valid), 64'd0);
        push_wb(WB_VEC[3]);
        step();
        chk("R2 still quiet", 64'(req_valid), 64'd0);
        chk("R8 not done with work held", 64'(walk_done), 64'd0);
        retry_pulse = 1'b1;
        step();
        expect_offer("R2 restart with read", 1'b0, 48'h00AB_C000);
        req_accept = 1'b1;
        step();
        for (int i = 0; i < 4; i++) begin
            expect_offer("R3 newest first", 1'b1, WB_VEC[3-i]);
            chk("R3 data", req_data, {16'h0, WB_VEC[3-i]} ^ WB_XOR);
            step();
        end
        chk("R3 stack drained", 64'(req_valid), 64'd0);
        for (int i = 0; i < 4; i++) begin
            respond(1'b0, 1'b1, WB_VEC[i], '0);
            step();
        end
        chk("R4 done low with read outstanding", 64'(walk_done), 64'd0);
        respond(1'b0, 1'b0, 48'h00AB_C000, 64'h1122_3344_5566_7788);
        step();
        chk("R7 rdata_valid", 64'(rdata_valid), 64'd1);
        chk("R7 rdata", rdata, 64'h1122_3344_5566_7788);
        chk("R7 no offer in hand-over", 64'(req_valid), 64'd0);
        chk("R8 not done in hand-over", 64'(walk_done), 64'd0);
        step();
        chk("R8 done after drain", 64'(walk_done), 64'd1);
        chk("R7 rdata_valid one cycle", 64'(rdata_valid), 64'd0);

        // ---- R7: follow-on read and write-back queued in hand-over cycle
        rd_enq_valid = 1'b1;
        rd_enq_addr  = 48'h0000_5000;
        step();
        expect_offer("R1 lone read", 1'b0, 48'h0000_5000);
        step();
        chk("R4 done low while read in flight", 64'(walk_done), 64'd0);
        respond(1'b0, 1'b0, 48'h0000_5000, 64'hDEAD_0000_BEEF_0001);
        step();
        chk("R7 hand-over", 64'(rdata_valid), 64'd1);
        rd_enq_valid = 1'b1;
        rd_enq_addr  = 48'h0000_6000;
        push_wb(48'h0000_5040);
        step();
        expect_offer("R7 follow-on read before write-back", 1'b0, 48'h0000_6000);
        step();
        expect_offer("R7 write-back after read", 1'b1, 48'h0000_5040);
        step();
        chk("R7 nothing left", 64'(req_valid), 64'd0);
        respond(1'b0, 1'b0, 48'h0000_6000, 64'h77);
        step();
        respond(1'b0, 1'b1, 48'h0000_5040, '0);
        step();
        chk("R8 done after walk", 64'(walk_done), 64'd1);

        // ---- R5 R6: refused responses re-offered, even while retrying
        rd_enq_valid = 1'b1;
        rd_enq_addr  = 48'h0000_7000;
        step();
        step();
        req_accept = 1'b0;
        push_wb(48'h0000_7100);
        step();
        expect_offer("R3 lone write-back", 1'b1, 48'h0000_7100);
        step();
        chk("R2 quiet after write refusal", 64'(req_valid), 64'd0);
        respond(1'b1, 1'b0, 48'h0000_7000, '0);
        step();
        expect_offer("R5 nack read re-offered while retrying", 1'b0, 48'h0000_7000);
        req_accept = 1'b1;
        step();
        chk("R2 write-back waits for retry", 64'(req_valid), 64'd0);
        retry_pulse = 1'b1;
        step();
        expect_offer("R2 write-back after retry", 1'b1, 48'h0000_7100);
        step();
        req_accept = 1'b0;
        respond(1'b1, 1'b1, 48'h0000_7100, 64'hCAFE_F00D_0000_0001);
        step();
        expect_offer("R5 nack write re-offered", 1'b1, 48'h0000_7100);
        chk("R5 write data kept", req_data, 64'hCAFE_F00D_0000_0001);
        step();
        chk("R6 quiet after refused re-offer", 64'(req_valid), 64'd0);
        chk("R8 not done with write returned", 64'(walk_done), 64'd0);
        retry_pulse = 1'b1;
        step();
        expect_offer("R6 write back on stack", 1'b1, 48'h0000_7100);
        chk("R6 data", req_data, 64'hCAFE_F00D_0000_0001);
        req_accept = 1'b1;
        step();
        respond(1'b0, 1'b0, 48'h0000_7000, 64'h5);
        step();
        respond(1'b0, 1'b1, 48'h0000_7100, '0);
        step();
        chk("R8 done after nack walk", 64'(walk_done), 64'd1);

        // ---- R6: refused read re-offer returns to the read slot
        rd_enq_valid = 1'b1;
        rd_enq_addr  = 48'h0000_8000;
        step();
        step();
        req_accept = 1'b0;
        respond(1'b1, 1'b0, 48'h0000_8000, '0);
        step();
        expect_offer("R5 read re-offer", 1'b0, 48'h0000_8000);
        step();
        chk("R6 quiet after refused read re-offer", 64'(req_valid), 64'd0);
        chk("R8 not done with read returned", 64'(walk_done), 64'd0);
        retry_pulse = 1'b1;
        step();
        expect_offer("R6 read back in slot", 1'b0, 48'h0000_8000);
        req_accept = 1'b1;
        step();
        respond(1'b0, 1'b0, 48'h0000_8000, 64'h9);
        step();
        step();
        chk("R8 done after returned read", 64'(walk_done), 64'd1);

        // ---- R9: overflow of the write-back stack
        apply_reset();
        for (int i = 0; i < 4; i++) begin
            push_wb(WB_VEC[i]);
            step();
        end
        chk("R9 no error at exactly full", 64'(err_wq_ovf), 64'd0);
        push_wb(48'h0000_9999);
        step();
        chk("R9 overflow flagged", 64'(err_wq_ovf), 64'd1);
        retry_pulse = 1'b1;
        step();
        req_accept = 1'b1;
        for (int i = 0; i < 4; i++) begin
            expect_offer("R9 kept entries in order", 1'b1, WB_VEC[3-i]);
            step();
        end
        chk("R9 extra entry dropped", 64'(req_valid), 64'd0);
        chk("R9 flag sticky", 64'(err_wq_ovf), 64'd1);
        chk("R10 flag untouched", 64'(err_rd_dup), 64'd0);
        for (int i = 0; i < 4; i++) begin
            respond(1'b0, 1'b1, WB_VEC[i], '0);
            step();
        end
        chk("R8 done after overflow drain", 64'(walk_done), 64'd1);

        // ---- R10: second read while one is pending
        apply_reset();
        chk("R11 overflow cleared by reset", 64'(err_wq_ovf), 64'd0);
        rd_enq_valid = 1'b1;
        rd_enq_addr  = 48'h0000_A000;
        step();
        expect_offer("R10 first read", 1'b0, 48'h0000_A000);
        rd_enq_valid = 1'b1;
        rd_enq_addr  = 48'h0000_B000;
        step();
        chk("R10 dup flagged", 64'(err_rd_dup), 64'd1);
        retry_pulse = 1'b1;
        step();
        req_accept = 1'b1;
        expect_offer("R10 original read kept", 1'b0, 48'h0000_A000);
        step();
        chk("R10 no second read", 64'(req_valid), 64'd0);
        respond(1'b0, 1'b0, 48'h0000_A000, 64'h3);
        step();
        step();
        chk("R8 done after dup case", 64'(walk_done), 64'd1);
        chk("R10 flag sticky", 64'(err_rd_dup), 64'd1);

        finish_run();
    end
endmodule